// File: doc/BRIEF.md
# Failing Transaction Tag Capture

This block keeps the internal transaction tag of failed transactions so that software can later find out what failed. Three error classes report into it: single-bit memory ECC, double-bit memory ECC, and bus/data-path errors. Each class has a strobe and the tag of the transaction that failed. Each class has one capture register. It loads the tag of the first error of that class and keeps it until software releases it.

While a capture register is valid, its tag is driven to the tag allocator as pinned, so that the tag cannot be reused. Software reads the registers through a small register port. Writing a one to the valid bit of a capture register releases it, and the block then sends a one-cycle retire pulse carrying the tag. A first-error status register and a next-error status register record the order in which the error classes arrived. Both are cleared per bit by writing ones.

The capture and status state is cleared only by power-on reset. A warm reset (also used for a bus-init event) freezes that state so that it can still be read after the reset.

Top module: `failtag_hold`

## Requirements
- R1: The register address map is: 0 is the single-bit capture, 1 is the double-bit capture, 2 is the bus capture, 3 is first-error status, 4 is next-error status. A capture register reads as valid in bit TAG_W and the tag in bits TAG_W-1:0. Status registers read with bit 0 for single-bit, bit 1 for double-bit and bit 2 for bus, and zero above.
- R2: An empty capture register loads the tag on the clock edge where its strobe is high. While it is valid, later strobes of that class leave it unchanged.
- R3: `pin_mask[i]` is high exactly while capture register i is valid, and `pin_tags[i*TAG_W +: TAG_W]` then carries its tag. The class index is 0 for single-bit, 1 for double-bit and 2 for bus.
- R4: A write of a one to bit TAG_W of a valid capture register clears the register. In the next cycle `retire_stb` is high for one cycle, with `retire_tag` set to the released tag. A write with that bit at zero, or a write to an empty register, does nothing.
- R5: While `warm_rst` is high, the capture and status registers hold, strobes and writes are ignored, and `reg_rdata`/`reg_rvalid` go to zero. `por` clears all state.
- R6: Any number of capture registers may be valid at once. Strobes of several classes on the same edge load all the empty registers.
- R7: When the first-error status is zero, an error sets the one bit of its class in that register. If several classes strobe together, the bit chosen is double-bit first, then bus, then single-bit. The register never holds more than one bit.
- R8: Every error that does not go into first-error status sets its class bit in next-error status. This includes errors of a class whose capture register is already valid.
- R9: A write to a status register clears the bits written as one and keeps the bits written as zero. An error arriving on the same edge as the clear is kept.
- R10: A release write and a strobe of the same class on the same edge: the release takes effect and the strobe is dropped.
- R11: A read request returns `reg_rdata` with `reg_rvalid` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset / bus-init, synchronous, active high |
| sbe_stb | input | 1 | Single-bit ECC error strobe |
| sbe_tag | input | TAG_W | Tag of the single-bit failure |
| dbe_stb | input | 1 | Double-bit ECC error strobe |
| dbe_tag | input | TAG_W | Tag of the double-bit failure |
| bus_stb | input | 1 | Bus/data-path error strobe |
| bus_tag | input | TAG_W | Tag of the bus failure |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read request |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | TAG_W+1 | Write data |
| reg_rdata | output | TAG_W+1 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| pin_mask | output | 3 | Per-class tag-pinned flags |
| pin_tags | output | 3*TAG_W | Pinned tags, class i in slice i |
| retire_stb | output | 1 | One-cycle retire pulse |
| retire_tag | output | TAG_W | Tag being retired |

## Verification
Two pairs of events can fall on the same edge. The first is a release write to a capture register together with a new strobe of the same class. The second is a write-one-to-clear of a status register together with a fresh error that sets a bit in that register. The bench drives both events in one cycle. For the first pair it checks that the old tag is retired and the register ends empty. For the second it reads the status back and checks that exactly the newly set bit survives the clear. Simultaneous strobes of several classes are driven while first-error status is empty, and the bench checks the priority order of the bit that is recorded.

// File: rtl/failtag_pkg.sv
package failtag_pkg;

  localparam int NCLS  = 3;
  localparam int C_SBE = 0;
  localparam int C_DBE = 1;
  localparam int C_BUS = 2;

  typedef enum logic [2:0] {
    A_SBE   = 3'd0,
    A_DBE   = 3'd1,
    A_BUS   = 3'd2,
    A_FIRST = 3'd3,
    A_NEXT  = 3'd4
  } reg_addr_e;

  // Fixed priority for simultaneous errors: double-bit, bus, single-bit.
  function automatic logic [NCLS-1:0] pick_first(input logic [NCLS-1:0] s);
    logic [NCLS-1:0] r;
    r = '0;
    if (s[C_DBE])      r[C_DBE] = 1'b1;
    else if (s[C_BUS]) r[C_BUS] = 1'b1;
    else if (s[C_SBE]) r[C_SBE] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/failtag_slot.sv
module failtag_slot #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             por,
  input  logic             hold,
  input  logic             stb,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             rel,
  output logic             vld,
  output logic [TAG_W-1:0] tag,
  output logic             ret
);

  always_ff @(posedge clk) begin
    if (por) begin
      vld <= 1'b0;
      tag <= '0;
      ret <= 1'b0;
    end else begin
      ret <= 1'b0;
      if (!hold) begin
        if (rel && vld) begin
          vld <= 1'b0;
          ret <= 1'b1;
        end else if (stb && !vld) begin
          vld <= 1'b1;
          tag <= tag_in;
        end
      end
    end
  end

  a_r2_ignore_later: assert property (@(posedge clk) disable iff (por)
    (vld && !rel) |=> (vld && $stable(tag)));

  a_r2_first_load: assert property (@(posedge clk) disable iff (por)
    (stb && !vld && !rel && !hold) |=> (vld && tag == $past(tag_in)));

  a_r4_release: assert property (@(posedge clk) disable iff (por)
    (vld && rel && !hold) |=> (!vld && ret));

  a_r5_warm_hold: assert property (@(posedge clk) disable iff (por)
    hold |=> ($stable(vld) && $stable(tag) && !ret));

endmodule

// File: rtl/failtag_status.sv
module failtag_status
  import failtag_pkg::*;
(
  input  logic            clk,
  input  logic            por,
  input  logic            hold,
  input  logic [NCLS-1:0] stb,
  input  logic            clr_first,
  input  logic            clr_next,
  input  logic [NCLS-1:0] wmask,
  output logic [NCLS-1:0] first,
  output logic [NCLS-1:0] next
);

  logic [NCLS-1:0] f_kept, win, first_d, next_d;

  always_comb begin
    f_kept  = first & ~(clr_first ? wmask : '0);
    win     = (f_kept == '0) ? pick_first(stb) : '0;
    first_d = f_kept | win;
    next_d  = (next & ~(clr_next ? wmask : '0)) | (stb & ~win);
  end

  always_ff @(posedge clk) begin
    if (por) begin
      first <= '0;
      next  <= '0;
    end else if (!hold) begin
      first <= first_d;
      next  <= next_d;
    end
  end

  a_r7_first_onehot: assert property (@(posedge clk) disable iff (por)
    $onehot0(first));

  a_r9_zero_write_keeps: assert property (@(posedge clk) disable iff (por)
    (clr_next && wmask == '0 && stb == '0) |=> $stable(next));

  for (genvar i = 0; i < NCLS; i++) begin : g_setwin
    a_r9_set_wins: assert property (@(posedge clk) disable iff (por)
      (stb[i] && !hold) |=> (first[i] || next[i]));
  end

endmodule

// File: rtl/failtag_regif.sv
module failtag_regif
  import failtag_pkg::*;
#(
  parameter int TAG_W = 8,
  localparam int RD_W = TAG_W + 1
) (
  input  logic                  clk,
  input  logic                  por,
  input  logic                  hold,
  input  logic                  we,
  input  logic                  re,
  input  logic [2:0]            addr,
  input  logic [RD_W-1:0]       wdata,
  input  logic [NCLS-1:0]       cap_vld,
  input  logic [NCLS*TAG_W-1:0] cap_tag,
  input  logic [NCLS-1:0]       first,
  input  logic [NCLS-1:0]       next,
  output logic [NCLS-1:0]       rel,
  output logic                  clr_first,
  output logic                  clr_next,
  output logic [NCLS-1:0]       wmask,
  output logic [RD_W-1:0]       rdata,
  output logic                  rvalid
);

  logic            wr_ok;
  logic [RD_W-1:0] rd_mux;
  logic            unused_wdata;

  assign wr_ok        = we && !hold;
  assign clr_first    = wr_ok && (addr == A_FIRST);
  assign clr_next     = wr_ok && (addr == A_NEXT);
  assign wmask        = wdata[NCLS-1:0];
  assign unused_wdata = ^wdata;

  for (genvar i = 0; i < NCLS; i++) begin : g_rel
    assign rel[i] = wr_ok && (addr == 3'(i)) && wdata[TAG_W];
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_SBE, A_DBE, A_BUS:
        rd_mux = {cap_vld[addr[1:0]], cap_tag[addr[1:0]*TAG_W +: TAG_W]};
      A_FIRST: rd_mux[NCLS-1:0] = first;
      A_NEXT:  rd_mux[NCLS-1:0] = next;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por || hold) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= rd_mux;
    end
  end

  a_r11_read_latency: assert property (@(posedge clk) disable iff (por)
    (re && !hold) |=> rvalid);

  a_r5_warm_rd_zero: assert property (@(posedge clk) disable iff (por)
    hold |=> (!rvalid && rdata == '0));

endmodule

// File: rtl/failtag_hold.sv
module failtag_hold
  import failtag_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic               clk,
  input  logic               por,
  input  logic               warm_rst,
  input  logic               sbe_stb,
  input  logic [TAG_W-1:0]   sbe_tag,
  input  logic               dbe_stb,
  input  logic [TAG_W-1:0]   dbe_tag,
  input  logic               bus_stb,
  input  logic [TAG_W-1:0]   bus_tag,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [2:0]         reg_addr,
  input  logic [TAG_W:0]     reg_wdata,
  output logic [TAG_W:0]     reg_rdata,
  output logic               reg_rvalid,
  output logic [2:0]         pin_mask,
  output logic [3*TAG_W-1:0] pin_tags,
  output logic               retire_stb,
  output logic [TAG_W-1:0]   retire_tag
);

  logic [NCLS-1:0]       stb_v, rel, ret, vld;
  logic [NCLS*TAG_W-1:0] tin, tags;
  logic [NCLS-1:0]       first, next, wmask;
  logic                  clr_first, clr_next;

  assign stb_v = {bus_stb, dbe_stb, sbe_stb};
  assign tin   = {bus_tag, dbe_tag, sbe_tag};

  for (genvar i = 0; i < NCLS; i++) begin : g_slot
    failtag_slot #(.TAG_W(TAG_W)) u_slot (
      .clk    (clk),
      .por    (por),
      .hold   (warm_rst),
      .stb    (stb_v[i]),
      .tag_in (tin[i*TAG_W +: TAG_W]),
      .rel    (rel[i]),
      .vld    (vld[i]),
      .tag    (tags[i*TAG_W +: TAG_W]),
      .ret    (ret[i])
    );
  end

  failtag_status u_status (
    .clk       (clk),
    .por       (por),
    .hold      (warm_rst),
    .stb       (stb_v),
    .clr_first (clr_first),
    .clr_next  (clr_next),
    .wmask     (wmask),
    .first     (first),
    .next      (next)
  );

  failtag_regif #(.TAG_W(TAG_W)) u_regif (
    .clk       (clk),
    .por       (por),
    .hold      (warm_rst),
    .we        (reg_we),
    .re        (reg_re),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .cap_vld   (vld),
    .cap_tag   (tags),
    .first     (first),
    .next      (next),
    .rel       (rel),
    .clr_first (clr_first),
    .clr_next  (clr_next),
    .wmask     (wmask),
    .rdata     (reg_rdata),
    .rvalid    (reg_rvalid)
  );

  assign pin_mask   = vld;
  assign pin_tags   = tags;
  assign retire_stb = |ret;

  always_comb begin
    retire_tag = '0;
    for (int i = 0; i < NCLS; i++)
      if (ret[i]) retire_tag = retire_tag | tags[i*TAG_W +: TAG_W];
  end

  a_r4_one_retire: assert property (@(posedge clk) disable iff (por)
    $onehot0(ret));

  a_r3_pin_release: assert property (@(posedge clk) disable iff (por)
    retire_stb |-> (pin_mask != $past(pin_mask)));

endmodule

// File: tb/failtag_hold_tb.sv
module failtag_hold_tb;

  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic por, warm_rst;
  logic sbe_stb, dbe_stb, bus_stb;
  logic [TAG_W-1:0] sbe_tag, dbe_tag, bus_tag;
  logic reg_we, reg_re;
  logic [2:0] reg_addr;
  logic [TAG_W:0] reg_wdata, reg_rdata;
  logic reg_rvalid;
  logic [2:0] pin_mask;
  logic [3*TAG_W-1:0] pin_tags;
  logic retire_stb;
  logic [TAG_W-1:0] retire_tag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  failtag_hold #(.TAG_W(TAG_W)) u_dut (.*);

  // {strobes[2:0], tag[7:0], exp mask[2:0], exp first[2:0], exp next[2:0]}
  localparam logic [19:0] VEC [4] = '{
    {3'b001, 8'h11, 3'b001, 3'b001, 3'b000},
    {3'b001, 8'h22, 3'b001, 3'b001, 3'b001},
    {3'b110, 8'h33, 3'b111, 3'b001, 3'b111},
    {3'b000, 8'h44, 3'b111, 3'b001, 3'b111}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    sbe_stb = 0; dbe_stb = 0; bus_stb = 0;
    reg_we = 0; reg_re = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [TAG_W:0] v);
    reg_re = 1; reg_addr = a;
    step();
    reg_re = 0;
    chk("R11 rvalid", 32'(reg_rvalid), 32'd1);
    v = reg_rdata;
  endtask

  task automatic strobe(input logic [2:0] s, input logic [TAG_W-1:0] t);
    sbe_stb = s[0]; dbe_stb = s[1]; bus_stb = s[2];
    sbe_tag = t; dbe_tag = t; bus_tag = t;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [TAG_W:0] v;
    por = 1; warm_rst = 0; idle(); reg_addr = 0; reg_wdata = 0;
    sbe_tag = 0; dbe_tag = 0; bus_tag = 0;
    step(); step();
    por = 0;
    step();
    chk("R5 por mask", 32'(pin_mask), 0);
    chk("R5 por retire", 32'(retire_stb), 0);

    // vector walk
    for (int k = 0; k < 4; k++) begin
      strobe(VEC[k][19:17], VEC[k][16:9]);
      step();
      idle();
      chk("R2 R3 R6 mask", 32'(pin_mask), 32'(VEC[k][8:6]));
      rd(3'd3, v);
      chk("R7 first", 32'(v), 32'(VEC[k][5:3]));
      rd(3'd4, v);
      chk("R8 next", 32'(v), 32'(VEC[k][2:0]));
    end
    chk("R2 R3 pin_tags", 32'(pin_tags), 32'h333311);

    rd(3'd0, v);
    chk("R1 read sbe", 32'(v), 32'h111);
    rd(3'd2, v);
    chk("R1 read bus", 32'(v), 32'h133);

    // R4: valid bit zero -> no effect
    reg_we = 1; reg_addr = 3'd1; reg_wdata = 9'h000;
    step(); idle();
    chk("R4 zero write retire", 32'(retire_stb), 0);
    chk("R4 zero write mask", 32'(pin_mask), 32'h7);

    // R4: release sbe
    reg_we = 1; reg_addr = 3'd0; reg_wdata = 9'h100;
    step(); idle();
    chk("R4 retire pulse", 32'(retire_stb), 1);
    chk("R4 retire tag", 32'(retire_tag), 32'h11);
    chk("R4 mask after", 32'(pin_mask), 32'h6);
    step();
    chk("R4 pulse one cycle", 32'(retire_stb), 0);

    // R4: release of empty register
    reg_we = 1; reg_addr = 3'd0; reg_wdata = 9'h100;
    step(); idle();
    chk("R4 empty release", 32'(retire_stb), 0);

    // R10: release bus with same-class strobe
    reg_we = 1; reg_addr = 3'd2; reg_wdata = 9'h100;
    strobe(3'b100, 8'h55);
    step(); idle();
    chk("R10 retire tag", 32'(retire_tag), 32'h33);
    chk("R10 mask", 32'(pin_mask), 32'h2);

    // R5: warm reset ignores strobes and writes
    rd(3'd1, v);
    warm_rst = 1;
    strobe(3'b001, 8'h66);
    reg_we = 1; reg_addr = 3'd1; reg_wdata = 9'h100;
    step(); idle();
    warm_rst = 0;
    chk("R5 warm mask", 32'(pin_mask), 32'h2);
    chk("R5 warm rdata", 32'(reg_rdata), 0);
    chk("R5 warm rvalid", 32'(reg_rvalid), 0);
    chk("R5 warm retire", 32'(retire_stb), 0);
    rd(3'd3, v);
    chk("R5 warm first kept", 32'(v), 32'h1);

    // R9: zeros leave status
    reg_we = 1; reg_addr = 3'd4; reg_wdata = 9'h000;
    step(); idle();
    rd(3'd4, v);
    chk("R9 zero write", 32'(v), 32'h7);

    // R9: clear next with a single-bit error on the same edge
    reg_we = 1; reg_addr = 3'd4; reg_wdata = 9'h007;
    strobe(3'b001, 8'h77);
    step(); idle();
    chk("R6 sbe reload", 32'(pin_mask), 32'h3);
    rd(3'd4, v);
    chk("R9 set wins", 32'(v), 32'h1);
    rd(3'd3, v);
    chk("R9 first untouched", 32'(v), 32'h1);

    reg_we = 1; reg_addr = 3'd3; reg_wdata = 9'h001;
    step(); idle();
    rd(3'd3, v);
    chk("R9 first cleared", 32'(v), 0);

    // R7: priority double over single
    strobe(3'b011, 8'h88);
    step(); idle();
    rd(3'd3, v);
    chk("R7 dbe wins", 32'(v), 32'h2);
    rd(3'd4, v);
    chk("R8 loser to next", 32'(v), 32'h1);
    chk("R2 tags kept", 32'(pin_tags[15:0]), 32'h3377);

    // R7: bus over single
    reg_we = 1; reg_addr = 3'd3; reg_wdata = 9'h007;
    step();
    reg_addr = 3'd4;
    step(); idle();
    strobe(3'b101, 8'h99);
    step(); idle();
    rd(3'd3, v);
    chk("R7 bus wins", 32'(v), 32'h4);
    rd(3'd4, v);
    chk("R8 sbe to next", 32'(v), 32'h1);
    chk("R6 all valid", 32'(pin_mask), 32'h7);

    // R5: power-on clears
    por = 1;
    step();
    por = 0;
    step();
    chk("R5 por clears mask", 32'(pin_mask), 0);
    rd(3'd0, v);
    chk("R5 por clears reg", 32'(v), 0);
    rd(3'd4, v);
    chk("R5 por clears next", 32'(v), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule